// File: doc/BRIEF.md
# Transport Stream Sync Lock with Hysteresis

This block finds and holds byte alignment on an MPEG-2 transport stream. The stream arrives either as whole bytes or as single bits. The block looks for the 0x47 sync byte and expects the next one 188 bytes later. It declares lock only after a programmed number of correctly spaced sync bytes in a row. It gives up lock only after a programmed number of sync slots in a row that do not carry 0x47. Lock is acquired and tracked by the hardware alone, with no processor involvement.

When bits arrive serially, the block slides an 8-bit window across the stream one bit at a time while it searches. On the first window that reads 0x47, it fixes the bit alignment. From then on it forms a byte from every eight valid bits. While locked, it delivers the aligned bytes with a strobe on each packet's sync byte and holds a lock flag high. Downstream logic, such as PID filtering, consumes these outputs.

Top module: `ts_sync_lock`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid`, `pkt_start` and `locked` are 0.
- R2: Lock is declared on the byte that completes `lock_thr` consecutive 0x47 bytes spaced exactly 188 bytes apart. That sync byte is delivered on `out_byte` with `out_valid` and `pkt_start` high, in the same cycle that `locked` rises.
- R3: Before lock is declared, `out_valid` and `pkt_start` stay 0.
- R4: During verification, a slot 188 bytes after the previous sync that does not hold 0x47 sends the block back to searching. A full new run of `lock_thr` good syncs is then needed.
- R5: While locked, a missing sync lets delivery continue, with `out_valid` high and `pkt_start` low, as long as the consecutive miss count stays below `unlock_thr`. A correct sync clears the miss count.
- R6: The `unlock_thr`-th consecutive missing sync drops `locked`. That byte is not delivered, and searching resumes.
- R7: A threshold value of 0 on `lock_thr` or `unlock_thr` behaves as 1.
- R8: With `ser_mode`=1, bits are taken most significant first. During search, every valid bit yields a candidate window. Once 0x47 is found, a byte is formed from each further group of 8 valid bits.
- R9: `pkt_start` is high only together with `out_valid` and `out_byte`=0x47 at an expected sync slot. While locked, successive strobes are a whole multiple of 188 delivered bytes apart.
- R10: An accepted byte (parallel) or the bit that completes a byte (serial) appears on the outputs two clock edges after it is sampled.
- R11: Cycles with the active mode's valid low do not advance the block. The inactive mode's inputs (`ser_valid`/`ser_bit` in parallel mode, `par_valid`/`par_byte` in serial mode) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 selects serial bit input, 0 selects parallel byte input; change only under reset |
| lock_thr | input | 4 | Consecutive good syncs needed to declare lock (0 acts as 1) |
| unlock_thr | input | 4 | Consecutive missed syncs needed to drop lock (0 acts as 1) |
| par_valid | input | 1 | Parallel byte present |
| par_byte | input | 8 | Parallel byte |
| ser_valid | input | 1 | Serial bit present |
| ser_bit | input | 1 | Serial bit, most significant first |
| out_valid | output | 1 | Aligned byte valid (only while locked) |
| out_byte | output | 8 | Aligned byte |
| pkt_start | output | 1 | Sync byte of a packet is on `out_byte` |
| locked | output | 1 | Lock status |

## Verification
Every result is due exactly two clock edges after the input that causes it is sampled. A sampled input is registered into the candidate stage, and the candidate then updates the state and the output registers. The bench drives inputs on the falling edge and runs a reference model on each input as it is driven. It holds the model's expectation in a two-deep queue and compares all outputs on the falling edge two cycles later. The comparison runs every cycle, so idle and gap cycles are covered too. Directed lock-status checks are made only after two idle cycles, so that the last sampled input has fully passed through both register stages.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;
endpackage

// File: rtl/ts_sync_byte_former.sv
// Turns the selected input lane into a stream of candidate bytes.
// Serial lane: while the tracker wants to search, each bit yields a window;
// otherwise a byte is formed every BYTE_W valid bits.
module ts_sync_byte_former #(
  parameter int BYTE_W    = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              hunt,
  input  logic              par_valid,
  input  logic [BYTE_W-1:0] par_byte,
  input  logic              ser_valid,
  input  logic              ser_bit,
  output logic              cand_valid,
  output logic [BYTE_W-1:0] cand_byte
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] win_q;
  logic [BYTE_W-1:0] win_d;
  logic [CNT_W-1:0]  bit_cnt_q;

  generate
    if (MSB_FIRST) begin : g_msb_first
      assign win_d = {win_q[BYTE_W-2:0], ser_bit};
    end else begin : g_lsb_first
      assign win_d = {ser_bit, win_q[BYTE_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= '0;
      bit_cnt_q  <= '0;
      cand_valid <= 1'b0;
      cand_byte  <= '0;
    end else begin
      cand_valid <= 1'b0;
      if (!ser_mode) begin
        if (par_valid) begin
          cand_valid <= 1'b1;
          cand_byte  <= par_byte;
        end
      end else if (ser_valid) begin
        win_q <= win_d;
        if (hunt || bit_cnt_q == LAST_BIT) begin
          cand_valid <= 1'b1;
          cand_byte  <= win_d;
          bit_cnt_q  <= '0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ts_sync_fsm.sv
// Search / verify / locked tracker with separate acquire and release counts.
module ts_sync_fsm
  import ts_sync_pkg::*;
#(
  parameter int                PKT_LEN  = 188,
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SYNC_VAL = 8'h47,
  parameter int                THR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_valid,
  input  logic [BYTE_W-1:0] cand_byte,
  input  logic [THR_W-1:0]  lock_thr,
  input  logic [THR_W-1:0]  unlock_thr,
  output logic              hunt_next,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              pkt_start,
  output logic              locked
);
  localparam int POS_W = $clog2(PKT_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);

  sync_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_inc;
  logic [THR_W-1:0] good_q, good_d, miss_q, miss_d;
  logic [THR_W-1:0] lock_lim, unlock_lim;
  logic [THR_W:0]   good_inc, miss_inc;
  logic             is_sync, at_slot, slot_hit, emit;

  assign lock_lim   = (lock_thr == '0)   ? THR_W'(1) : lock_thr;
  assign unlock_lim = (unlock_thr == '0) ? THR_W'(1) : unlock_thr;
  assign is_sync    = (cand_byte == SYNC_VAL);
  assign at_slot    = (pos_q == '0);
  assign pos_inc    = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  assign good_inc   = {1'b0, good_q} + 1'b1;
  assign miss_inc   = {1'b0, miss_q} + 1'b1;

  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    good_d   = good_q;
    miss_d   = miss_q;
    slot_hit = 1'b0;
    if (cand_valid) begin
      case (state_q)
        ST_HUNT: begin
          if (is_sync) begin
            slot_hit = 1'b1;
            pos_d    = POS_W'(1);
            good_d   = THR_W'(1);
            miss_d   = '0;
            state_d  = (lock_lim == THR_W'(1)) ? ST_LOCKED : ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          pos_d = pos_inc;
          if (at_slot) begin
            if (is_sync) begin
              slot_hit = 1'b1;
              good_d   = good_inc[THR_W-1:0];
              if (good_inc >= {1'b0, lock_lim}) state_d = ST_LOCKED;
            end else begin
              state_d = ST_HUNT;
            end
          end
        end
        ST_LOCKED: begin
          pos_d = pos_inc;
          if (at_slot) begin
            if (is_sync) begin
              slot_hit = 1'b1;
              miss_d   = '0;
            end else begin
              miss_d = miss_inc[THR_W-1:0];
              if (miss_inc >= {1'b0, unlock_lim}) state_d = ST_HUNT;
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  assign hunt_next = (state_d == ST_HUNT);
  assign emit      = cand_valid && (state_d == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HUNT;
      pos_q     <= '0;
      good_q    <= '0;
      miss_q    <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      pkt_start <= 1'b0;
      locked    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pos_q     <= pos_d;
      good_q    <= good_d;
      miss_q    <= miss_d;
      out_valid <= emit;
      pkt_start <= emit && slot_hit;
      locked    <= (state_d == ST_LOCKED);
      if (emit) out_byte <= cand_byte;
    end
  end
endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock #(
  parameter int                PKT_LEN   = 188,
  parameter int                BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] SYNC_VAL  = 8'h47,
  parameter int                THR_W     = 4,
  parameter bit                MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic [THR_W-1:0]  lock_thr,
  input  logic [THR_W-1:0]  unlock_thr,
  input  logic              par_valid,
  input  logic [BYTE_W-1:0] par_byte,
  input  logic              ser_valid,
  input  logic              ser_bit,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              pkt_start,
  output logic              locked
);
  logic              cand_valid;
  logic [BYTE_W-1:0] cand_byte;
  logic              hunt_next;

  ts_sync_byte_former #(
    .BYTE_W   (BYTE_W),
    .MSB_FIRST(MSB_FIRST)
  ) u_former (
    .clk       (clk),
    .rst       (rst),
    .ser_mode  (ser_mode),
    .hunt      (hunt_next),
    .par_valid (par_valid),
    .par_byte  (par_byte),
    .ser_valid (ser_valid),
    .ser_bit   (ser_bit),
    .cand_valid(cand_valid),
    .cand_byte (cand_byte)
  );

  ts_sync_fsm #(
    .PKT_LEN (PKT_LEN),
    .BYTE_W  (BYTE_W),
    .SYNC_VAL(SYNC_VAL),
    .THR_W   (THR_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cand_valid(cand_valid),
    .cand_byte (cand_byte),
    .lock_thr  (lock_thr),
    .unlock_thr(unlock_thr),
    .hunt_next (hunt_next),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .pkt_start (pkt_start),
    .locked    (locked)
  );
endmodule

// File: rtl/ts_sync_lock_chk.sv
module ts_sync_lock_chk #(
  parameter int                PKT_LEN  = 188,
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] SYNC_VAL = 8'h47
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_mode,
  input logic              par_valid,
  input logic              ser_valid,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_byte,
  input logic              pkt_start,
  input logic              locked
);
  localparam int POS_W = $clog2(PKT_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);

  logic [POS_W-1:0] phase_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      phase_q <= '0;
      seen_q  <= 1'b0;
    end else if (out_valid) begin
      if (pkt_start) begin
        phase_q <= POS_W'(1);
        seen_q  <= 1'b1;
      end else begin
        phase_q <= (phase_q == POS_LAST) ? '0 : phase_q + 1'b1;
      end
    end
  end

  a_r3_out_needs_lock: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> locked);

  a_r9_start_is_sync: assert property (@(posedge clk) disable iff (rst)
    pkt_start |-> (out_valid && out_byte == SYNC_VAL));

  a_r2_lock_on_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> pkt_start);

  a_r6_drop_silent: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> !out_valid);

  a_r9_start_spacing: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && seen_q) |-> (phase_q == '0));

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ser_mode ? $past(ser_valid, 2) : $past(par_valid, 2)));
endmodule

bind ts_sync_lock ts_sync_lock_chk #(
  .PKT_LEN (PKT_LEN),
  .BYTE_W  (BYTE_W),
  .SYNC_VAL(SYNC_VAL)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_mode (ser_mode),
  .par_valid(par_valid),
  .ser_valid(ser_valid),
  .out_valid(out_valid),
  .out_byte (out_byte),
  .pkt_start(pkt_start),
  .locked   (locked)
);

// File: tb/test_ts_sync_lock.sv
module test_ts_sync_lock;
  localparam int PKT = 188;

  logic       clk = 1'b0;
  logic       rst;
  logic       ser_mode;
  logic [3:0] lock_thr, unlock_thr;
  logic       par_valid;
  logic [7:0] par_byte;
  logic       ser_valid, ser_bit;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       pkt_start, locked;

  always #10 clk = ~clk;

  ts_sync_lock i_ts_sync_lock (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .lock_thr(lock_thr),
    .unlock_thr(unlock_thr), .par_valid(par_valid), .par_byte(par_byte),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .out_valid(out_valid),
    .out_byte(out_byte), .pkt_start(pkt_start), .locked(locked)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  typedef struct packed {
    logic       v;
    logic [7:0] b;
    logic       s;
    logic       l;
  } exp_t;

  exp_t p1, p2;

  // reference model state: 0 search, 1 verify, 2 locked
  int         m_st, m_pos, m_good, m_miss, m_bc;
  logic [7:0] m_sr;

  function automatic int lim(input logic [3:0] t);
    return (t == 4'd0) ? 1 : int'(t);
  endfunction

  task automatic model_cand(input logic [7:0] b, inout exp_t e);
    int   nxt;
    logic hit;
    nxt = m_st;
    hit = 1'b0;
    if (m_st == 0) begin
      if (b == 8'h47) begin
        hit = 1'b1; m_pos = 1; m_good = 1; m_miss = 0;
        nxt = (lim(lock_thr) <= 1) ? 2 : 1;
      end
    end else begin
      if (m_pos == 0) begin
        if (b == 8'h47) begin
          hit = 1'b1;
          if (m_st == 1) begin
            m_good++;
            if (m_good >= lim(lock_thr)) nxt = 2;
          end else m_miss = 0;
        end else if (m_st == 1) begin
          nxt = 0;
        end else begin
          m_miss++;
          if (m_miss >= lim(unlock_thr)) nxt = 0;
        end
      end
      m_pos = (m_pos == PKT - 1) ? 0 : m_pos + 1;
    end
    m_st = nxt;
    if (nxt == 2) begin
      e.v = 1'b1; e.b = b; e.s = hit;
    end
  endtask

  task automatic model_bit(input logic bt, inout exp_t e);
    m_sr = {m_sr[6:0], bt};
    if (m_st == 0 || m_bc == 7) begin
      m_bc = 0;
      model_cand(m_sr, e);
    end else m_bc++;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: compare the result due now, then drive and model the next input
  task automatic step(input logic pv, input logic [7:0] pb, input logic sv, input logic sb);
    exp_t e;
    @(negedge clk);
    n_chk++;
    if (out_valid !== p2.v || pkt_start !== p2.s || locked !== p2.l ||
        (p2.v && out_byte !== p2.b)) begin
      n_err++;
      $display("FAIL %s cycle: actual v=%0b s=%0b l=%0b b=%0h expected v=%0b s=%0b l=%0b b=%0h",
               cur_req, out_valid, pkt_start, locked, out_byte, p2.v, p2.s, p2.l, p2.b);
    end
    p2 = p1;
    par_valid = pv; par_byte = pb; ser_valid = sv; ser_bit = sb;
    e = '0;
    if (!ser_mode && pv) model_cand(pb, e);
    if (ser_mode && sv) model_bit(sb, e);
    e.l = (m_st == 2);
    p1 = e;
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // two idle cycles so the last input has passed both register stages
  task automatic check_lock(input logic exp, input string req);
    idle(); idle();
    chk(locked === exp, req, "locked", int'(locked), int'(exp));
  endtask

  task automatic do_reset(input logic mode, input logic [3:0] lt, input logic [3:0] ut);
    @(negedge clk);
    rst = 1'b1; ser_mode = mode; lock_thr = lt; unlock_thr = ut;
    par_valid = 1'b0; par_byte = 8'h00; ser_valid = 1'b0; ser_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(out_valid === 1'b0 && pkt_start === 1'b0 && locked === 1'b0, "R1",
        "reset outputs", int'({out_valid, pkt_start, locked}), 0);
    rst = 1'b0;
    m_st = 0; m_pos = 0; m_good = 0; m_miss = 0; m_bc = 0; m_sr = 8'h00;
    p1 = '0; p2 = '0;
  endtask

  function automatic logic [7:0] payload();
    logic [7:0] b;
    b = 8'($urandom);
    if (b == 8'h47) b = 8'h46;
    return b;
  endfunction

  task automatic send_par(input bit good, input int gap_pct);
    logic [7:0] b;
    for (int i = 0; i < PKT; i++) begin
      b = (i == 0) ? (good ? 8'h47 : 8'h07) : payload();
      while (int'($urandom_range(99)) < gap_pct)
        step(1'b0, 8'h47, 1'($urandom), 1'($urandom));   // R11 noise on idle lanes
      step(1'b1, b, 1'($urandom), 1'($urandom));
    end
  endtask

  task automatic send_ser(input bit good, input int gap_pct);
    logic [7:0] b;
    for (int i = 0; i < PKT; i++) begin
      b = (i == 0) ? (good ? 8'h47 : 8'h07) : payload();
      for (int k = 7; k >= 0; k--) begin
        while (int'($urandom_range(99)) < gap_pct)
          step(1'($urandom), 8'h47, 1'b0, 1'($urandom));
        step(1'($urandom), 8'($urandom), 1'b1, b[k]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    p1 = '0; p2 = '0;

    // parallel, acquire after 3, release after 2
    do_reset(1'b0, 4'd3, 4'd2);
    cur_req = "R3 R10";
    for (int i = 0; i < 5; i++) step(1'b1, payload(), 1'b0, 1'b0);
    send_par(1, 0); send_par(1, 0);
    check_lock(1'b0, "R3");
    cur_req = "R2 R9 R10";
    send_par(1, 0);
    check_lock(1'b1, "R2");

    cur_req = "R5 R9";
    send_par(0, 0); send_par(1, 0); send_par(0, 0); send_par(1, 0);
    check_lock(1'b1, "R5");

    cur_req = "R6";
    send_par(0, 0); send_par(0, 0);
    check_lock(1'b0, "R6");

    cur_req = "R4";
    send_par(1, 0); send_par(1, 0); send_par(0, 0);
    send_par(1, 0); send_par(1, 0);
    check_lock(1'b0, "R4");
    send_par(1, 0);
    check_lock(1'b1, "R4");

    // zero thresholds act as one
    do_reset(1'b0, 4'd0, 4'd0);
    cur_req = "R7";
    send_par(1, 0);
    check_lock(1'b1, "R7");
    send_par(0, 0);
    check_lock(1'b0, "R7");

    // gaps and noise on the serial lane
    do_reset(1'b0, 4'd1, 4'd15);
    cur_req = "R11 R9";
    send_par(1, 30); send_par(1, 30); send_par(0, 30); send_par(1, 30);
    check_lock(1'b1, "R11");

    // serial lane, misaligned start
    do_reset(1'b1, 4'd2, 4'd2);
    cur_req = "R8 R10";
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, 1'($urandom));
    for (int i = 0; i < 6; i++) send_ser(1, 20);
    check_lock(1'b1, "R8");
    send_ser(0, 20); send_ser(0, 20);
    check_lock(1'b0, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule